// File: doc/BRIEF.md
# Inter-Core Interrupt Send Dispatcher

Any core in a multi-core cluster can raise an interrupt on another core by writing a 32-bit send command. This block decodes that command and turns it into a posting for exactly one target core. The posting is a one-hot pattern for that core's 32-bit interrupt status register. The command carries a target core number and a vector number that picks one of the 32 status bits. The block drives a set-bits bus that is split into one 32-bit lane per core. The per-core status registers sit outside this block and OR the lane into their status, which is the same as a software write of a single set bit.

A command can name a core that does not exist. When its target number is at or above the configured core count, the block answers with a decode error in the same cycle as the strobe and posts nothing anywhere. The block accepts a new command on every clock cycle. The core that issued a command is never involved: the posting always goes to the addressed target.

Top module: `ipi_send_dispatch`

## Requirements
- R1: During and right after synchronous active-low reset, `set_bits` is all zero and `decode_err` is low.
- R2: The target core number is command bits 25:16 (10 bits). A valid in-range command posts only into lane `t` (bits `t*32+31 : t*32` of `set_bits`), and every other lane is zero in that cycle.
- R3: The vector is command bits 4:0. The posted lane value is exactly `1 << vector`, so one bit is set.
- R4: The posting appears on `set_bits` in the clock cycle after the strobe and lasts exactly one cycle unless another command follows.
- R5: When `cmd_valid` is high and the target number is at or above `NUM_CORES`, `decode_err` is high in that same cycle, and in the next cycle `set_bits` is all zero.
- R6: When `cmd_valid` is low, `decode_err` is low and the next cycle's `set_bits` is all zero, whatever `cmd_word` holds.
- R7: Command bits 31:26 and 15:5 have no effect on `set_bits` or `decode_err`.
- R8: Commands on consecutive cycles are each accepted, and each produces its own posting one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Send command strobe, one command per high cycle |
| cmd_word | input | 32 | Send command: target in 25:16, vector in 4:0 |
| set_bits | output | NUM_CORES*32 | Per-core set pulses, lane t in bits t*32+31:t*32 |
| decode_err | output | 1 | Target out of range, same cycle as strobe |

## Verification
The only internal state is the registered set-bit lanes, so any fault there shows on `set_bits` one cycle after the command that caused it. A stale pulse appears as a non-zero lane in a cycle that follows an idle or rejected command. A misrouted pulse appears as the wrong lane or bit at that same edge. Range-check faults show on `decode_err` combinationally, in the strobe cycle itself. Random commands are mixed with boundary targets: the last valid core, the first invalid number and the all-ones field. This mix exposes off-by-one decoding at once.

// File: rtl/ipi_disp_pkg.sv
// Package: shared field positions and helpers for the send dispatcher.
// Assumes a 32-bit command word with target and vector fields that do not overlap.
package ipi_disp_pkg;
    localparam int CMD_W    = 32;
    localparam int ID_LSB   = 16;
    localparam int ID_W     = 10;
    localparam int VEC_LSB  = 0;
    localparam int VEC_W    = 5;
    localparam int STATUS_W = 1 << VEC_W;

    typedef logic [ID_W-1:0]     tgt_id_t;
    typedef logic [VEC_W-1:0]    vec_t;
    typedef logic [STATUS_W-1:0] status_t;

    // Decoded view of one send command.
    typedef struct packed {
        tgt_id_t tgt;
        vec_t    vec;
    } send_cmd_t;
endpackage

// File: rtl/cmd_field_decode.sv
// Module: splits a send command into target and vector, and range-checks the target.
// Assumes NUM_CORES is between 1 and 2**ID_W. Purely combinational.
module cmd_field_decode
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [CMD_W-1:0] cmd,
    output send_cmd_t        fields,
    output logic             tgt_ok
);
    localparam logic [31:0] CORE_LIMIT = 32'(NUM_CORES);

    logic [31:0] tgt_ext;

    // Pull the two fields out of their fixed positions.
    always_comb begin
        fields.tgt = cmd[ID_LSB +: ID_W];
        fields.vec = cmd[VEC_LSB +: VEC_W];
    end

    // Target is accepted only when it names an existing core.
    always_comb begin
        tgt_ext = 32'(fields.tgt);
        tgt_ok  = (tgt_ext < CORE_LIMIT);
    end
endmodule

// File: rtl/vec_onehot.sv
// Module: turns a vector number into a one-hot status pattern.
// Assumes the output width is exactly 2**VEC_W. Purely combinational.
module vec_onehot
    import ipi_disp_pkg::*;
(
    input  vec_t    vec,
    output status_t pattern
);
    // One bit per status position, set where the index equals the vector.
    always_comb begin
        for (int b = 0; b < STATUS_W; b++) begin
            pattern[b] = (vec == vec_t'(b));
        end
    end
endmodule

// File: rtl/core_post_lane.sv
// Module: registers the set pulse for one target core.
// Assumes hit is high for at most one lane per cycle; synchronous active-low reset.
module core_post_lane
    import ipi_disp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  status_t pattern,
    output status_t lane_q
);
    // Hold the pattern for one cycle when this core is addressed, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (hit) begin
            lane_q <= pattern;
        end else begin
            lane_q <= '0;
        end
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
// Module: top of the send dispatcher. Decodes a command and posts a one-hot
// set pulse into the lane of the addressed core on the next cycle. It reports
// an out-of-range target combinationally in the strobe cycle.
// Assumes one command per cycle and that the status registers OR in their lane.
module ipi_send_dispatch
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [31:0]                   cmd_word,
    output logic [NUM_CORES*STATUS_W-1:0] set_bits,
    output logic                          decode_err
);
    send_cmd_t fields;
    logic      tgt_ok;
    status_t   pattern;
    logic [NUM_CORES-1:0] lane_hit;

    cmd_field_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .cmd    (cmd_word),
        .fields (fields),
        .tgt_ok (tgt_ok)
    );

    vec_onehot u_vec (
        .vec     (fields.vec),
        .pattern (pattern)
    );

    // Reject a strobed command whose target does not exist.
    always_comb begin
        decode_err = cmd_valid && !tgt_ok;
    end

    // One lane per core: select on target match, then register the pulse.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
        always_comb begin
            lane_hit[c] = cmd_valid && tgt_ok && (fields.tgt == tgt_id_t'(c));
        end

        core_post_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (lane_hit[c]),
            .pattern (pattern),
            .lane_q  (set_bits[c*STATUS_W +: STATUS_W])
        );
    end
endmodule

// File: rtl/ipi_send_dispatch_chk.sv
// Checker: temporal properties of the dispatcher, bound to the top module.
// Assumes it sees the top's ports under the same names.
module ipi_send_dispatch_chk
    import ipi_disp_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cmd_valid,
    input logic [31:0]                   cmd_word,
    input logic [NUM_CORES*STATUS_W-1:0] set_bits,
    input logic                          decode_err
);
    // R6
    err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |-> cmd_valid);

    // R2
    single_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_bits));

    // R3
    accept_posts_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !decode_err) |=> ($countones(set_bits) == 1));

    // R5
    reject_posts_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decode_err |=> (set_bits == '0));

    // R6
    idle_posts_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (set_bits == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (set_bits == '0));
endmodule

bind ipi_send_dispatch ipi_send_dispatch_chk #(.NUM_CORES(NUM_CORES)) u_chk (.*);

// File: tb/sim_ipi_send_dispatch.sv
// Bench: fixed-seed random commands mixed with directed corner cases.
module sim_ipi_send_dispatch;
    localparam int NC = 4;
    localparam int SW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [31:0]     cmd_word = '0;
    logic [NC*SW-1:0] set_bits;
    logic            decode_err;

    int checks = 0;
    int errors = 0;
    logic [NC*SW-1:0] exp_next = '0;
    string            prev_req = "R1";

    ipi_send_dispatch #(.NUM_CORES(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .set_bits(set_bits), .decode_err(decode_err)
    );

    always #10 clk = ~clk;

    // Expected error from the requirements: strobe with target >= NC.
    function automatic logic f_err(logic v, logic [31:0] c);
        return v && (int'(c[25:16]) >= NC);
    endfunction

    // Expected posting one cycle later.
    function automatic logic [NC*SW-1:0] f_set(logic v, logic [31:0] c);
        logic [NC*SW-1:0] r;
        r = '0;
        if (v && int'(c[25:16]) < NC) r[int'(c[25:16])*SW + int'(c[4:0])] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] mk(int tgt, int vec, logic [31:0] junk);
        logic [31:0] w;
        w = junk & 32'hFC00_FFE0;
        w[25:16] = 10'(tgt);
        w[4:0] = 5'(vec);
        return w;
    endfunction

    // One cycle: check last posting, drive a new command, check its error.
    task automatic step(logic v, logic [31:0] c, string req);
        @(negedge clk);
        checks++;
        if (set_bits !== exp_next) begin
            errors++;
            $display("FAIL %s set_bits actual=%h expected=%h", prev_req, set_bits, exp_next);
        end
        cmd_valid = v;
        cmd_word = c;
        #1;
        checks++;
        if (decode_err !== f_err(v, c)) begin
            errors++;
            $display("FAIL %s decode_err actual=%b expected=%b", req, decode_err, f_err(v, c));
        end
        exp_next = f_set(v, c);
        prev_req = req;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (set_bits !== '0 || decode_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", set_bits, decode_err);
        end
        rst_n = 1'b1;
        step(1'b0, 32'hFFFF_FFFF, "R6");
        // R2 / R3: each core, low and high vector
        for (int t = 0; t < NC; t++) begin
            step(1'b1, mk(t, 0, '0), "R2");
            step(1'b1, mk(t, 31, '0), "R3");
        end
        step(1'b0, '0, "R4");
        // R5: first invalid, all-ones target, then valid back-to-back
        step(1'b1, mk(NC, 7, '0), "R5");
        step(1'b1, mk(1023, 3, '0), "R5");
        step(1'b1, mk(NC-1, 9, '0), "R8");
        step(1'b1, mk(0, 17, '0), "R8");
        // R7: junk in the ignored bits
        step(1'b1, mk(2, 12, 32'hFFFF_FFFF), "R7");
        step(1'b1, mk(NC+1, 12, 32'hA5A5_A5A5), "R7");
        // R6: idle with a live-looking word
        step(1'b0, mk(1, 4, '0), "R6");
        step(1'b0, mk(1, 4, '0), "R6");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic v;
            int t;
            v = ($urandom % 4) != 0;
            t = ($urandom % 8 == 0) ? int'($urandom % 1024) : int'($urandom % (NC + 2));
            step(v, mk(t, int'($urandom % 32), $urandom), v ? "R8" : "R6");
        end
        // R4: pulse ends after one cycle
        step(1'b0, '0, "R4");
        step(1'b0, '0, "R4");
        // Reset mid-stream clears the pending posting
        step(1'b1, mk(1, 5, '0), "R1");
        rst_n = 1'b0;
        exp_next = '0;
        step(1'b0, '0, "R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule